// File: doc/BRIEF.md
# Conflict-Free Tile Transpose Buffer

This block holds one square tile of 32-bit words and hands it back transposed. A producer writes the tile one row per beat, with every element of the row presented at once on its own lane. The block then produces one column per beat, with lane `r` of the output carrying the element that came from row `r`. After the last column it is ready for the next tile.

Storage is split into one single-port-per-direction bank per lane, and consecutive words of the linear address space go to consecutive banks. Each row of the tile is placed one word further along than a dense layout would put it, so element (row `r`, column `c`) sits at linear word `r*(N+1) + c` and lives in bank `(r + c) mod N`. Whether a beat is a row write or a column read, its N elements then fall in N different banks. A column read therefore finishes in a single cycle instead of queuing N accesses on one bank. Per-bank and per-lane selectors rotate the data so that each element reaches its bank on the way in and its lane on the way out.

A two-state controller orders the work. In `ST_FILL` the block accepts row beats. The transition *fill_to_drain* fires on the accepted beat for row N-1. In `ST_DRAIN` it emits one column per cycle. The transition *drain_to_fill* fires on the column N-1 beat, which also raises `out_done`. Idle cycles in `ST_FILL` hold the state, and so does the self-loop *fill_hold*.

Top module: `tile_transpose_buf`

## Requirements
- R1: While `rst_n` is low and right after reset, `in_ready` is 1, `out_valid` is 0 and `out_done` is 0.
- R2: In the fill state, a cycle with `in_valid` and `in_ready` both high stores one row. Rows are numbered 0 to N-1 in arrival order, and lane `c` is bits `[c*W +: W]` of `in_row`. The beat for row N-1 moves the block to the drain state on the next cycle.
- R3: A fill-state cycle with `in_valid` low stores nothing and does not advance the row count. The rows that follow still land in order.
- R4: In the drain state, `out_valid` is 1 and `in_ready` is 0 for exactly N consecutive cycles. `in_valid` and `in_row` are ignored there and do not change any stored element.
- R5: Drain beat `k` (k = 0..N-1) carries column `k`: lane `r` of `out_col` (bits `[r*W +: W]`) equals the lane `k` element of row `r`.
- R6: `out_done` is 1 only on drain beat N-1.
- R7: The cycle after `out_done`, the block is back in the fill state with `in_ready` = 1. The next tile's row 0 may be accepted in that cycle.
- R8: Element (r, c) is stored at linear word `r*(N+1)+c` in bank `(r*(N+1)+c) mod N`. Within every beat, the N lanes address N distinct banks, so row beats are accepted and column beats produced on consecutive cycles with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A row beat is offered |
| in_row | input | N*W | Row elements, lane c at [c*W +: W] |
| in_ready | output | 1 | High in the fill state |
| out_valid | output | 1 | A column beat is on `out_col` |
| out_col | output | N*W | Column elements, lane r at [r*W +: W] |
| out_done | output | 1 | Marks the last column beat of a tile |

## Verification
Some properties are checked on every clock by assertions. The lane-to-bank map of each beat must be a permutation, which is the conflict-free property. The two phases must never overlap. `out_done` may only appear inside the drain phase and must be followed by a return to fill. Both phases must have the right length, counted from observed handshakes. The transposed data itself, the handling of idle fill cycles, and the immunity of stored data to writes offered during drain can only be shown by the bench's scenarios. The bench runs random tiles, a patterned tile, a tile sent with gaps, and noise on the inputs during drain, and compares every cycle with a behavioural model.

// File: rtl/tt_pkg.sv
package tt_pkg;
    typedef enum logic {
        ST_FILL  = 1'b0,
        ST_DRAIN = 1'b1
    } tt_state_e;
endpackage

// File: rtl/tt_addr_gen.sv
// Padded-stride address generator. The beat index is fixed across a beat
// (row on write, column on read); the other coordinate moves across banks.
module tt_addr_gen #(
    parameter int N = 16
) (
    input  logic [$clog2(N)-1:0]         fixed_idx,
    input  logic                         is_write,
    output logic [N*$clog2(N)-1:0]       bank_src_flat,
    output logic [N*$clog2(N+1)-1:0]     bank_slot_flat,
    output logic [N*$clog2(N)-1:0]       lane_bank_flat
);
    localparam int LN = $clog2(N);
    localparam int LS = $clog2(N + 1);
    localparam int AW = $clog2(N * (N + 1));

    for (genvar b = 0; b < N; b++) begin : g_bank
        logic [LN-1:0] moving;
        logic [AW-1:0] lin;
        always_comb begin
            moving = LN'(b) - fixed_idx;
            if (is_write)
                lin = AW'(fixed_idx) * AW'(N + 1) + AW'(moving);
            else
                lin = AW'(moving) * AW'(N + 1) + AW'(fixed_idx);
        end
        assign bank_src_flat[b*LN +: LN]  = moving;
        assign bank_slot_flat[b*LS +: LS] = LS'(lin >> LN);
    end

    for (genvar j = 0; j < N; j++) begin : g_lane
        assign lane_bank_flat[j*LN +: LN] = LN'(j) + fixed_idx;
    end
endmodule

// File: rtl/tt_xbar.sv
// N-way selector: output j takes input sel[j].
module tt_xbar #(
    parameter int N = 16,
    parameter int W = 32
) (
    input  logic [N*W-1:0]         in_flat,
    input  logic [N*$clog2(N)-1:0] sel_flat,
    output logic [N*W-1:0]         out_flat
);
    localparam int LN = $clog2(N);
    for (genvar j = 0; j < N; j++) begin : g_out
        logic [LN-1:0] sel;
        assign sel = sel_flat[j*LN +: LN];
        assign out_flat[j*W +: W] = in_flat[sel*W +: W];
    end
endmodule

// File: rtl/tt_bank.sv
// One storage bank: one word written and one word read per cycle.
module tt_bank #(
    parameter int W     = 32,
    parameter int DEPTH = 17
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] wslot,
    input  logic [W-1:0]             wdata,
    input  logic [$clog2(DEPTH)-1:0] rslot,
    output logic [W-1:0]             rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[wslot] <= wdata;
    end

    assign rdata = mem[rslot];
endmodule

// File: rtl/tile_transpose_buf.sv
module tile_transpose_buf #(
    parameter int N = 16,
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [N*W-1:0] in_row,
    output logic         in_ready,
    output logic         out_valid,
    output logic [N*W-1:0] out_col,
    output logic         out_done
);
    import tt_pkg::*;

    localparam int LN    = $clog2(N);
    localparam int DEPTH = N + 1;
    localparam int LS    = $clog2(DEPTH);

    tt_state_e state, state_nx;
    logic [LN-1:0] idx, idx_nx;
    logic          wr_en;
    logic          last_idx;

    logic [N*LN-1:0] bank_src_flat;
    logic [N*LS-1:0] bank_slot_flat;
    logic [N*LN-1:0] lane_bank_flat;
    logic [N*W-1:0]  bank_wdata_flat;
    logic [N*W-1:0]  bank_rdata_flat;

    assign last_idx = (idx == LN'(N - 1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_FILL;
            idx   <= '0;
        end else begin
            state <= state_nx;
            idx   <= idx_nx;
        end
    end

    // next state and outputs
    always_comb begin
        state_nx  = state;
        idx_nx    = idx;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_done  = 1'b0;
        wr_en     = 1'b0;
        unique case (state)
            ST_FILL: begin
                in_ready = 1'b1;
                wr_en    = in_valid;
                if (in_valid) begin
                    idx_nx = idx + 1'b1;
                    if (last_idx) state_nx = ST_DRAIN;   // fill_to_drain
                end                                       // else fill_hold
            end
            ST_DRAIN: begin
                out_valid = 1'b1;
                out_done  = last_idx;
                idx_nx    = idx + 1'b1;
                if (last_idx) state_nx = ST_FILL;         // drain_to_fill
            end
            default: state_nx = ST_FILL;
        endcase
    end

    tt_addr_gen #(.N(N)) u_addr (
        .fixed_idx      (idx),
        .is_write       (state == ST_FILL),
        .bank_src_flat  (bank_src_flat),
        .bank_slot_flat (bank_slot_flat),
        .lane_bank_flat (lane_bank_flat)
    );

    tt_xbar #(.N(N), .W(W)) u_wr_xbar (
        .in_flat  (in_row),
        .sel_flat (bank_src_flat),
        .out_flat (bank_wdata_flat)
    );

    for (genvar b = 0; b < N; b++) begin : g_banks
        tt_bank #(.W(W), .DEPTH(DEPTH)) u_bank (
            .clk   (clk),
            .we    (wr_en),
            .wslot (bank_slot_flat[b*LS +: LS]),
            .wdata (bank_wdata_flat[b*W +: W]),
            .rslot (bank_slot_flat[b*LS +: LS]),
            .rdata (bank_rdata_flat[b*W +: W])
        );
    end

    tt_xbar #(.N(N), .W(W)) u_rd_xbar (
        .in_flat  (bank_rdata_flat),
        .sel_flat (lane_bank_flat),
        .out_flat (out_col)
    );
endmodule

// File: rtl/tt_chk.sv
module tt_chk #(
    parameter int N = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input logic                   in_ready,
    input logic                   out_valid,
    input logic                   out_done,
    input logic [N*$clog2(N)-1:0] lane_bank_flat
);
    localparam int LN = $clog2(N);

    logic [N-1:0]  seen;
    logic [LN:0]   acc_cnt;
    logic [LN:0]   drn_cnt;

    always_comb begin
        seen = '0;
        for (int j = 0; j < N; j++) seen[lane_bank_flat[j*LN +: LN]] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_cnt <= '0;
            drn_cnt <= '0;
        end else begin
            if (in_valid && in_ready)
                acc_cnt <= (acc_cnt == (LN+1)'(N - 1)) ? '0 : acc_cnt + 1'b1;
            if (out_valid)
                drn_cnt <= (drn_cnt == (LN+1)'(N - 1)) ? '0 : drn_cnt + 1'b1;
        end
    end

    // R8
    bank_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready || out_valid) |-> (&seen));

    // R4
    phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    // R6
    done_in_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> (out_valid && drn_cnt == (LN+1)'(N - 1)));

    // R7
    done_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |=> (in_ready && !out_valid));

    // R2
    fill_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && acc_cnt == (LN+1)'(N - 1)) |=> out_valid);

    // R4
    drain_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_done) |=> out_valid);
endmodule

bind tile_transpose_buf tt_chk #(.N(N)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (in_valid),
    .in_ready       (in_ready),
    .out_valid      (out_valid),
    .out_done       (out_done),
    .lane_bank_flat (lane_bank_flat)
);

// File: tb/tile_transpose_buf_test.sv
module tile_transpose_buf_test;
    localparam int N = 16;
    localparam int W = 32;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0;
    logic [N*W-1:0] in_row = '0;
    logic           in_ready, out_valid, out_done;
    logic [N*W-1:0] out_col;

    int tests = 0;
    int fails = 0;

    logic [W-1:0] tile [N][N];
    bit m_fill = 1'b1;
    int m_idx  = 0;

    always #4 clk = ~clk;

    tile_transpose_buf #(.N(N), .W(W)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_row(in_row),
        .in_ready(in_ready), .out_valid(out_valid), .out_col(out_col),
        .out_done(out_done)
    );

    task automatic chk(input string req, input logic [N*W-1:0] act, input logic [N*W-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // One clock: drive, compare with the model, then advance the model.
    task automatic cycle(input bit v, input logic [N*W-1:0] row);
        logic [N*W-1:0] exp_col;
        @(negedge clk);
        in_valid = v;
        in_row   = row;
        #1;
        chk("R2/R3 in_ready", {{(N*W-1){1'b0}}, in_ready}, {{(N*W-1){1'b0}}, m_fill});
        chk("R4/R8 out_valid", {{(N*W-1){1'b0}}, out_valid}, {{(N*W-1){1'b0}}, !m_fill});
        chk("R6 out_done", {{(N*W-1){1'b0}}, out_done},
            {{(N*W-1){1'b0}}, (!m_fill && m_idx == N-1)});
        if (!m_fill) begin
            for (int r = 0; r < N; r++) exp_col[r*W +: W] = tile[r][m_idx];
            chk("R5 out_col", out_col, exp_col);
        end
        @(posedge clk);
        if (m_fill) begin
            if (v) begin
                for (int c = 0; c < N; c++) tile[m_idx][c] = row[c*W +: W];
                if (m_idx == N-1) begin m_fill = 1'b0; m_idx = 0; end
                else m_idx++;
            end
        end else begin
            if (m_idx == N-1) begin m_fill = 1'b1; m_idx = 0; end
            else m_idx++;
        end
    endtask

    // mode 0: random; 1: pattern r*N+c. gap: idle every third row. noise: in_valid during drain.
    task automatic run_tile(input int mode, input bit gap, input bit noise);
        logic [N*W-1:0] row;
        for (int r = 0; r < N; r++) begin
            for (int c = 0; c < N; c++)
                row[c*W +: W] = (mode == 1) ? W'(r*N + c) : W'($urandom);
            if (gap && (r % 3 == 1)) cycle(1'b0, ~row);   // R3 idle beat
            cycle(1'b1, row);
        end
        for (int k = 0; k < N; k++) begin
            for (int c = 0; c < N; c++) row[c*W +: W] = W'($urandom);
            cycle(noise, row);                            // R4 noise ignored
        end
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset values
        chk("R1 in_ready", {{(N*W-1){1'b0}}, in_ready}, {{(N*W-1){1'b0}}, 1'b1});
        chk("R1 out_valid", {{(N*W-1){1'b0}}, out_valid}, '0);
        chk("R1 out_done", {{(N*W-1){1'b0}}, out_done}, '0);
        rst_n = 1'b1;
        run_tile(1, 1'b0, 1'b0);   // R5 patterned tile
        run_tile(0, 1'b1, 1'b1);   // R3 gaps, R4 noise
        run_tile(0, 1'b0, 1'b0);   // R7 back-to-back tiles
        run_tile(0, 1'b0, 1'b1);
        cycle(1'b0, '0);           // R7 idle after tile
        run_tile(0, 1'b1, 1'b0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule